// File: doc/BRIEF.md
# SPI-to-Parallel Flash Programming Bridge

This block is an SPI slave that gives an external host word-level read and write access to a 16-bit parallel flash. Each transfer is one chip-select frame. The frame carries a 4-bit command followed by a 16-bit word. The command picks a direction, picks whether the word is the address or the data, and can request that the address step by one after the data access. The block holds the address in a register and drives the flash address bus from it at all times. It produces the chip-enable, output-enable and write-enable strobes itself.

The SPI pins are oversampled by the system clock. The serial clock must run well below the system clock: each serial-clock phase must last at least ten system clocks at the default parameters. The host changes MOSI after a falling serial-clock edge, and the block samples MOSI on the rising edge. MISO follows the same rule. The block holds no flash command sequences (unlock, erase, status polling). The host builds these from ordinary data-write frames.

There is no streaming path at the block edge. Every SPI and flash pin is a plain level or strobe, so there is no valid/ready pair and no back-pressure to state. The host must keep an idle gap of at least twenty system clocks between frames so that a write can finish.

Top module: `spi_flash_bridge`

## Requirements
- R1: A frame is the time while `spi_cs_n` is low. MOSI is sampled on rising `spi_sclk` edges, first the 4 command bits and then 16 word bits, each MSB first. Returned words appear on MISO MSB first. MISO changes only after a falling edge, so the first returned bit is already valid before the fifth rising edge.
- R2: The command nibble is decoded as follows. Bit 3 is 1 for a write and 0 for a read. Bit 2 is 1 for the address and 0 for data. Bit 1 requests an address increment. Bit 0 has no effect.
- R3: A complete address-write frame (`11xx`) loads the 16-bit word into the address register, and `flash_addr` shows it.
- R4: An address-read frame (`01xx`) returns the current address register on MISO.
- R5: A complete data-write frame (`10xx`) makes exactly one flash write at the current address. `flash_we_n` is low for `WE_CYCLES` system clocks while `flash_ce_n` is low. The address and the driven data are stable from one cycle before the falling edge of write enable to one cycle after its rising edge.
- R6: In a data-read frame (`00xx`), `flash_ce_n` and `flash_oe_n` go low for `RD_CYCLES` clocks after the fourth command bit. The captured word is then shifted out on MISO.
- R7: `flash_oe_n` and `flash_we_n` are never low together. The block never drives `flash_dq` while output enable is low.
- R8: With bit 1 set, a completed data frame (read or write) adds one to the address after the access. The address wraps from 0xFFFF to 0x0000.
- R9: With bit 1 clear, the address register keeps its value across data frames.
- R10: If `spi_cs_n` rises before all 20 bits are received, the frame is abandoned. No flash write happens and the address does not change.
- R11: After reset, all flash strobes are high, `flash_dq` is released, the address is 0 and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| flash_addr | output | WORD_W | Flash word address |
| flash_dq | inout | WORD_W | Flash data bus, driven only during writes |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
The following are checked on every clock:
- Strobe exclusivity.
- Bus release during reads.
- Write-enable width, measured with a counter.
- Setup and hold of address and data around the write pulse.
- Address stability when no step or load occurs.
- Single-step wrap.
- Bit-counter limits while the frame select is high.

The bench scenarios cover what only whole transactions can show:
- Words returned MSB first through a flash model.
- Read data matching earlier writes.
- The unused command bit changing nothing.
- Increment-and-wrap across frames.
- Aborted frames leaving both memory and address untouched.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  localparam int CMD_BITS = 4;

  // decoded command fields; the lowest command bit is not stored
  typedef struct packed {
    logic wr;       // 1: host writes, 0: host reads
    logic is_addr;  // 1: word is the address, 0: word is flash data
    logic inc;      // step address after the data access
  } sfb_cmd_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RD,
    SEQ_WSETUP,
    SEQ_WPULSE,
    SEQ_WHOLD
  } seq_state_t;

endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sfb_spi_front.sv
module sfb_spi_front
  import sfb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              cmd_vld,
  output sfb_cmd_t          cmd,
  output logic              frame_done,
  output logic [WORD_W-1:0] rx_word
);

  localparam int FRAME_BITS = CMD_BITS + WORD_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic sclk_s, cs_s, mosi_s, sclk_d;
  logic rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] rx_sh, tx_q;

  sfb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk, cs_n, mosi}),
    .q    ({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d & ~cs_s;
  assign fall = ~sclk_s & sclk_d & ~cs_s;

  // receive side: bit counter, input shift, command capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rx_sh      <= '0;
      cmd        <= '0;
      cmd_vld    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      cmd_vld    <= 1'b0;
      frame_done <= 1'b0;
      if (cs_s) begin
        cnt <= '0;
      end else if (rise && cnt < CNT_W'(FRAME_BITS)) begin
        rx_sh <= {rx_sh[WORD_W-2:0], mosi_s};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(CMD_BITS - 1)) begin
          cmd     <= rx_sh[2:0];
          cmd_vld <= 1'b1;
        end
        if (cnt == CNT_W'(FRAME_BITS - 1)) frame_done <= 1'b1;
      end
    end
  end

  // transmit side: load wins, shift only on falls after a data bit was taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (cs_s) begin
      tx_q <= '0;
    end else if (tx_load) begin
      tx_q <= tx_word;
    end else if (fall && cnt > CNT_W'(CMD_BITS)) begin
      tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  assign miso    = tx_q[WORD_W-1];
  assign rx_word = rx_sh;

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));
  p_idle_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0));
  p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso);
  p_cmd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld);
  p_done_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (cnt == CNT_W'(FRAME_BITS)));

endmodule

// File: rtl/sfb_addr_reg.sv
module sfb_addr_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  output logic [WORD_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + 1'b1;
  end

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));
  p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr == $past(addr) + WORD_W'(1)));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(load_val)));

endmodule

// File: rtl/sfb_flash_seq.sv
module sfb_flash_seq
  import sfb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WE_CYCLES = 4,
  parameter int RD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic              wr_inc,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] addr_in,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              rd_done,
  output logic [WORD_W-1:0] rd_data,
  output logic              step
);

  localparam int TMAX = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
  localparam int TW = $clog2(TMAX + 1);

  seq_state_t state;
  logic [TW-1:0] tmr;
  logic inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      tmr     <= '0;
      inc_q   <= 1'b0;
      dq_out  <= '0;
      rd_data <= '0;
      rd_done <= 1'b0;
      step    <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      step    <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (rd_start) begin
            state <= SEQ_RD;
            tmr   <= TW'(RD_CYCLES - 1);
          end else if (wr_start) begin
            state  <= SEQ_WSETUP;
            dq_out <= wr_data;
            inc_q  <= wr_inc;
          end
        end
        SEQ_RD: begin
          if (tmr == '0) begin
            rd_data <= dq_in;
            rd_done <= 1'b1;
            state   <= SEQ_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        SEQ_WSETUP: begin
          state <= SEQ_WPULSE;
          tmr   <= TW'(WE_CYCLES - 1);
        end
        SEQ_WPULSE: begin
          if (tmr == '0) state <= SEQ_WHOLD;
          else           tmr   <= tmr - 1'b1;
        end
        SEQ_WHOLD: begin
          step  <= inc_q;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign ce_n  = (state == SEQ_IDLE);
  assign oe_n  = (state != SEQ_RD);
  assign we_n  = (state != SEQ_WPULSE);
  assign dq_oe = (state == SEQ_WSETUP) || (state == SEQ_WPULSE) || (state == SEQ_WHOLD);

  // checker-side width counter for the write pulse
  logic [TW:0] we_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    we_low <= '0;
    else if (we_n) we_low <= '0;
    else           we_low <= we_low + 1'b1;
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  p_no_drive_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  p_we_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ($past(dq_oe) && $past(!ce_n)));
  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && !ce_n));
  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_low == (TW+1)'(WE_CYCLES)));
  p_wr_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> ($stable(addr_in) && $stable(dq_out)));
  p_rd_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(!oe_n && !ce_n));

endmodule

// File: rtl/spi_flash_bridge.sv
module spi_flash_bridge
  import sfb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WE_CYCLES = 4,
  parameter int RD_CYCLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [WORD_W-1:0] flash_addr,
  inout  wire  [WORD_W-1:0] flash_dq,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n
);

  sfb_cmd_t cmd;
  logic cmd_vld, frame_done;
  logic [WORD_W-1:0] rx_word, tx_word, addr, dq_out, rd_data;
  logic tx_load, dq_oe, rd_done, wr_step;
  logic addr_load, wr_start, rd_start, rd_step, addr_step, addr_rd;

  sfb_spi_front #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso),
    .tx_load   (tx_load),
    .tx_word   (tx_word),
    .cmd_vld   (cmd_vld),
    .cmd       (cmd),
    .frame_done(frame_done),
    .rx_word   (rx_word)
  );

  // frame decode
  assign addr_load = frame_done &  cmd.wr &  cmd.is_addr;
  assign wr_start  = frame_done &  cmd.wr & ~cmd.is_addr;
  assign rd_start  = cmd_vld    & ~cmd.wr & ~cmd.is_addr;
  assign addr_rd   = cmd_vld    & ~cmd.wr &  cmd.is_addr;
  assign rd_step   = frame_done & ~cmd.wr & ~cmd.is_addr & cmd.inc;
  assign addr_step = rd_step | wr_step;

  assign tx_load = rd_done | addr_rd;
  assign tx_word = rd_done ? rd_data : addr;

  sfb_addr_reg #(.WORD_W(WORD_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (addr_load),
    .load_val(rx_word),
    .step    (addr_step),
    .addr    (addr)
  );

  sfb_flash_seq #(.WORD_W(WORD_W), .WE_CYCLES(WE_CYCLES), .RD_CYCLES(RD_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_start(rd_start),
    .wr_start(wr_start),
    .wr_inc  (cmd.inc),
    .wr_data (rx_word),
    .addr_in (addr),
    .dq_in   (flash_dq),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .ce_n    (flash_ce_n),
    .oe_n    (flash_oe_n),
    .we_n    (flash_we_n),
    .rd_done (rd_done),
    .rd_data (rd_data),
    .step    (wr_step)
  );

  assign flash_addr = addr;
  assign flash_dq   = dq_oe ? dq_out : {WORD_W{1'bz}};

  p_start_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, wr_start, rd_start, addr_rd}));
  p_step_not_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_step && addr_load));

endmodule

// File: tb/test_spi_flash_bridge.sv
`timescale 1ns/1ps
module test_spi_flash_bridge;

  localparam int HALF = 10;
  localparam int GAP  = 12;
  localparam int WE_CYCLES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [15:0] flash_addr;
  wire  [15:0] flash_dq;
  logic flash_ce_n, flash_oe_n, flash_we_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  spi_flash_bridge i_spi_flash_bridge (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .flash_addr(flash_addr), .flash_dq(flash_dq),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
  );

  // flash model: 256 words, aliased on the low address byte
  logic [15:0] fmem [256];
  logic [15:0] ref_mem [256];
  logic [15:0] ref_addr;

  function automatic logic [15:0] seed_word(int i);
    return 16'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  initial for (int i = 0; i < 256; i++) begin fmem[i] = seed_word(i); ref_mem[i] = seed_word(i); end

  assign flash_dq = (!flash_ce_n && !flash_oe_n) ? fmem[flash_addr[7:0]] : 16'hzzzz;

  always @(posedge flash_we_n) if (rst_n && !flash_ce_n) fmem[flash_addr[7:0]] <= flash_dq;

  // write-pulse and overlap monitor
  int pulses = 0, last_width = 0, low_run = 0, overlap = 0;
  always @(negedge clk) if (rst_n) begin
    if (!flash_we_n) low_run++;
    else if (low_run != 0) begin pulses++; last_width = low_run; low_run = 0; end
    if (!flash_we_n && !flash_oe_n) overlap++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [3:0] c, input logic [15:0] w, input int nbits,
                          output logic [15:0] got);
    logic [19:0] tx;
    tx = {c, w};
    got = '0;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[19-i];
      repeat (HALF) @(negedge clk);
      if (i >= 4) got = {got[14:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic set_addr(input logic [15:0] a);
    logic [15:0] g;
    spi_xfer(4'b1100, a, 20, g);
    ref_addr = a;
  endtask

  task automatic read_addr(output logic [15:0] a);
    spi_xfer(4'b0100, 16'h0, 20, a);
  endtask

  task automatic write_data(input logic [15:0] d, input logic inc, input logic spare);
    logic [15:0] g;
    spi_xfer({2'b10, inc, spare}, d, 20, g);
    ref_mem[ref_addr[7:0]] = d;
    if (inc) ref_addr = ref_addr + 16'd1;
  endtask

  task automatic read_data(input logic inc, output logic [15:0] got, output logic [15:0] exp);
    spi_xfer({2'b00, inc, 1'b0}, 16'h0, 20, got);
    exp = ref_mem[ref_addr[7:0]];
    if (inc) ref_addr = ref_addr + 16'd1;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] got, exp, a;
    int p0;
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 ce_n", 16'(flash_ce_n), 16'h1);
    chk("R11 oe_n", 16'(flash_oe_n), 16'h1);
    chk("R11 we_n", 16'(flash_we_n), 16'h1);
    chk("R11 miso", 16'(spi_miso), 16'h0);
    chk("R11 addr", flash_addr, 16'h0000);

    // R3 / R4 address load and readback
    set_addr(16'h1234);
    chk("R3 flash_addr", flash_addr, 16'h1234);
    read_addr(a);
    chk("R4 addr readback", a, 16'h1234);

    // R6 / R1 data read MSB first, R9 no step
    read_data(1'b0, got, exp);
    chk("R6 R1 read word", got, exp);
    read_addr(a);
    chk("R9 addr kept after read", a, 16'h1234);

    // R5 write pulse and storage
    p0 = pulses;
    write_data(16'hBEEF, 1'b0, 1'b0);
    chk("R5 one pulse", 16'(pulses - p0), 16'd1);
    chk("R5 pulse width", 16'(last_width), 16'(WE_CYCLES));
    read_data(1'b0, got, exp);
    chk("R5 write readback", got, 16'hBEEF);
    read_addr(a);
    chk("R9 addr kept after write", a, 16'h1234);

    // R2 unused bit 0 set: behaves as plain write with increment
    write_data(16'h0F0F, 1'b1, 1'b1);
    read_addr(a);
    chk("R2 spare bit, addr step", a, 16'h1235);
    set_addr(16'h1234);
    read_data(1'b0, got, exp);
    chk("R2 spare bit, data", got, 16'h0F0F);

    // R8 sequential reads with increment
    set_addr(16'h0040);
    for (int k = 0; k < 3; k++) begin
      read_data(1'b1, got, exp);
      chk("R8 burst read", got, exp);
    end
    chk("R8 addr after burst", flash_addr, 16'h0043);

    // R8 wrap on write and on read
    set_addr(16'hFFFF);
    write_data(16'h5A5A, 1'b1, 1'b0);
    read_addr(a);
    chk("R8 write wrap", a, 16'h0000);
    set_addr(16'hFFFF);
    read_data(1'b1, got, exp);
    chk("R8 read at top", got, 16'h5A5A);
    chk("R8 read wrap", flash_addr, 16'h0000);

    // R10 aborted write
    set_addr(16'h0077);
    p0 = pulses;
    spi_xfer(4'b1010, 16'hDEAD, 12, got);
    chk("R10 no pulse on abort", 16'(pulses - p0), 16'd0);
    chk("R10 addr kept on abort", flash_addr, 16'h0077);
    read_data(1'b0, got, exp);
    chk("R10 memory untouched", got, exp);

    // R10 aborted read with increment
    spi_xfer(4'b0010, 16'h0, 10, got);
    read_addr(a);
    chk("R10 no step on aborted read", a, 16'h0077);

    // random write / readback
    for (int n = 0; n < 30; n++) begin
      logic [15:0] ra, rd;
      logic ri;
      ra = 16'($urandom);
      rd = 16'($urandom);
      ri = 1'($urandom);
      set_addr(ra);
      write_data(rd, ri, 1'($urandom));
      chk("R8 R9 random addr", flash_addr, ri ? ra + 16'd1 : ra);
      set_addr(ra);
      read_data(1'b0, got, exp);
      chk("R5 R6 random data", got, rd);
    end

    chk("R7 no strobe overlap", 16'(overlap), 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule